// File: doc/BRIEF.md
# Emulated Two-Clock Dual-Port RAM

This block gives two independent read/write ports onto one memory array that is built from single-clock storage. Port A is clocked by a slow clock and port B by a fast clock, and the array itself is clocked by the fast clock. Each port A command (write flag, read flag, address, write data) is packed into an asynchronous FIFO that carries it into the fast domain. Read data for port A returns to the slow domain through a second asynchronous FIFO. Because the path crosses two clock domains, the port A read latency is not fixed, and a one-cycle valid strobe marks each returned word.

Port B drives the array directly and always has a two-cycle registered read latency. In the fast domain, a fixed arbiter gives the array to port B whenever port B presents a command. A queued port A command is served only in a fast cycle that port B leaves idle. Port A sees backpressure through a ready output, which is low while the command FIFO is full. For the port A latency bound to hold, the fast clock must be at least seven times the slow clock. Each FIFO depth must also be a power of two larger than that ratio. By default the FIFO depth is the same as the array depth.

Top module: `dcram_emu`

## Requirements
- R1: A port B read (b_ce=1, b_rd=1) sampled at one clk_b edge appears on b_rdata after the second clk_b edge. A command with both b_wr=1 and b_rd=1 returns the word held before that write.
- R2: A port B write (b_ce=1, b_wr=1) updates the array. A port B command with b_ce=0 changes nothing.
- R3: b_rdata is 0 after reset. It keeps its value in every cycle that follows a clk_b edge at which no port B read was sampled, including cycles where b_ce=0 or only a write was sampled.
- R4: A port A command is taken at a clk_a edge when a_ce=1, a_wr or a_rd is 1, and a_ready=1. A command with a_ce=0 has no effect. a_ready is 1 after reset.
- R5: a_ready falls once the command FIFO holds 2^FIFO_AW unserved commands. While port B issues a command on every clk_b cycle, exactly 2^FIFO_AW port A commands are accepted. A command offered while a_ready=0 is dropped.
- R6: Each accepted port A read returns exactly one word, with a_valid=1 for one clk_a cycle per word. Words return in issue order. A command with both a_wr and a_rd returns the word held before its write. a_rdata is 0 after reset and holds its value while a_valid=0. a_valid is 0 after reset.
- R7: A port A read appears on a_valid no sooner than 5 clk_a edges after the edge that accepted it. With a clock ratio of at least 7 and port B idle, it appears no later than 7 edges after.
- R8: Both ports access one shared array. A word written by either port is read back by the other.
- R9: Port B keeps its two-cycle latency while port A traffic is pending. Port A commands are served only in clk_b cycles with no port B command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Slow clock for port A |
| rst_a_n | input | 1 | Active-low asynchronous reset, slow domain |
| a_ce | input | 1 | Port A clock enable; gates command acceptance |
| a_wr | input | 1 | Port A write request |
| a_rd | input | 1 | Port A read request |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_ready | output | 1 | Port A command FIFO can accept |
| a_rdata | output | DW | Port A read data |
| a_valid | output | 1 | a_rdata carries a returned word this cycle |
| clk_b | input | 1 | Fast clock for port B and the array |
| rst_b_n | input | 1 | Active-low asynchronous reset, fast domain |
| b_ce | input | 1 | Port B clock enable |
| b_wr | input | 1 | Port B write request |
| b_rd | input | 1 | Port B read request |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, two cycles after the read |

## Verification
Each kind of internal fault shows up at a different port, and on a different time scale:

- **Pointer or Gray-code error in the command FIFO.** This shows on port A as lost, duplicated or reordered responses, or a_ready falling after the wrong number of accepted commands. It surfaces within a few slow cycles of the affected command.
- **Arbitration error.** This shows on port B as a wrong or late word two fast cycles after a read. It can also show as a port A command that corrupts a location port B is using.
- **Return-path error.** Too few synchronizer stages or a missing output stage shows up as an a_valid pulse earlier than five slow cycles after issue. A stuck return path shows up as responses that never drain.

// File: rtl/tdpe_pkg.sv
package tdpe_pkg;

    // Array owner for one fast-clock cycle
    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_B    = 2'd1,
        GNT_A    = 2'd2
    } grant_e;

    // Synchronizer depth below which the 5-cycle port A minimum is lost
    localparam int MIN_SYNC_STAGES = 3;

endpackage

// File: rtl/tdpe_sync.sv
module tdpe_sync #(
    parameter int W = 4,
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [N];

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) st_q[0] <= '0;
                    else        st_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) st_q[i] <= '0;
                    else        st_q[i] <= st_q[i-1];
                end
            end
        end
    endgenerate

    assign q = st_q[N-1];
endmodule

// File: rtl/tdpe_afifo.sv
module tdpe_afifo #(
    parameter int W    = 8,
    parameter int AW   = 4,   // depth is 2**AW, AW >= 2
    parameter int SYNC = 3
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic         wfull,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_en,
    output logic [W-1:0] rdata,
    output logic         rempty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin_q, wbin_d, wgray_q, wgray_d;
    logic [AW:0]  rbin_q, rbin_d, rgray_q, rgray_d;
    logic [AW:0]  rgray_w, wgray_r;

    tdpe_sync #(.W(AW+1), .N(SYNC)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w));
    tdpe_sync #(.W(AW+1), .N(SYNC)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r));

    always_comb begin
        wbin_d  = wbin_q + {{AW{1'b0}}, wr_en};
        wgray_d = wbin_d ^ (wbin_d >> 1);
        rbin_d  = rbin_q + {{AW{1'b0}}, rd_en};
        rgray_d = rbin_d ^ (rbin_d >> 1);
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else begin
            wbin_q  <= wbin_d;
            wgray_q <= wgray_d;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en) mem[wbin_q[AW-1:0]] <= wdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else begin
            rbin_q  <= rbin_d;
            rgray_q <= rgray_d;
        end
    end

    assign wfull  = (wgray_q == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    assign rempty = (rgray_q == wgray_r);
    assign rdata  = mem[rbin_q[AW-1:0]];

    // R5: a push is never presented to a full FIFO
    assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |-> !wfull);

    // R6: a pop is never presented to an empty FIFO
    assert_no_underflow_R6: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_en |-> !rempty);

    // R6: the crossing pointer changes by at most one bit per edge
    assert_gray_step_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/tdpe_array.sv
module tdpe_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata_q
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // read-first single-port storage
    always_ff @(posedge clk) begin
        if (en) begin
            rdata_q <= mem[addr];
            if (we) mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/dcram_emu.sv
module dcram_emu #(
    parameter int DW          = 16,
    parameter int AW          = 6,
    parameter int FIFO_AW     = AW,
    parameter int SYNC_STAGES = tdpe_pkg::MIN_SYNC_STAGES
) (
    input  logic          clk_a,
    input  logic          rst_a_n,
    input  logic          a_ce,
    input  logic          a_wr,
    input  logic          a_rd,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic          a_ready,
    output logic [DW-1:0] a_rdata,
    output logic          a_valid,
    input  logic          clk_b,
    input  logic          rst_b_n,
    input  logic          b_ce,
    input  logic          b_wr,
    input  logic          b_rd,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    import tdpe_pkg::*;

    localparam int REQ_W = 2 + AW + DW;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } areq_t;

    typedef struct packed {
        logic          b_rd1;
        logic          a_rd1;
        logic [DW-1:0] b_rdata;
    } fast_t;

    typedef struct packed {
        logic          s1_valid;
        logic [DW-1:0] s1_data;
        logic          a_valid;
        logic [DW-1:0] a_rdata;
    } slow_t;

    // ---------------- slow side: command entry ----------------
    areq_t          req_in, req_head;
    logic [REQ_W-1:0] req_head_raw;
    logic           req_full, req_empty, req_push, req_pop;

    assign req_in   = '{wr: a_wr, rd: a_rd, addr: a_addr, data: a_wdata};
    assign req_push = a_ce && (a_wr || a_rd) && !req_full;
    assign a_ready  = !req_full;

    tdpe_afifo #(.W(REQ_W), .AW(FIFO_AW), .SYNC(SYNC_STAGES)) u_req_fifo (
        .wclk(clk_a), .wrst_n(rst_a_n), .wr_en(req_push), .wdata(req_in),
        .wfull(req_full),
        .rclk(clk_b), .rrst_n(rst_b_n), .rd_en(req_pop), .rdata(req_head_raw),
        .rempty(req_empty));

    assign req_head = areq_t'(req_head_raw);

    // ---------------- fast side: arbitration and array ----------------
    fast_t          f_q, f_d;
    grant_e         grant;
    logic           b_req;
    logic           resp_full, resp_empty, resp_pop;
    logic           ram_en, ram_we;
    logic [AW-1:0]  ram_addr;
    logic [DW-1:0]  ram_wdata, ram_rdata, resp_rdata;

    always_comb begin
        b_req = b_ce && (b_wr || b_rd);
        grant = GNT_NONE;
        if (b_req)
            grant = GNT_B;
        else if (!req_empty && (!req_head.rd || (!resp_full && !f_q.a_rd1)))
            grant = GNT_A;

        ram_en    = (grant != GNT_NONE);
        ram_we    = (grant == GNT_B) ? b_wr    : req_head.wr;
        ram_addr  = (grant == GNT_B) ? b_addr  : req_head.addr;
        ram_wdata = (grant == GNT_B) ? b_wdata : req_head.data;
        req_pop   = (grant == GNT_A);

        f_d         = f_q;
        f_d.b_rd1   = (grant == GNT_B) && b_rd;
        f_d.a_rd1   = (grant == GNT_A) && req_head.rd;
        f_d.b_rdata = f_q.b_rd1 ? ram_rdata : f_q.b_rdata;
    end

    always_ff @(posedge clk_b or negedge rst_b_n) begin
        if (!rst_b_n) f_q <= '0;
        else          f_q <= f_d;
    end

    tdpe_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk_b), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata_q(ram_rdata));

    assign b_rdata = f_q.b_rdata;

    // ---------------- return path ----------------
    tdpe_afifo #(.W(DW), .AW(FIFO_AW), .SYNC(SYNC_STAGES)) u_resp_fifo (
        .wclk(clk_b), .wrst_n(rst_b_n), .wr_en(f_q.a_rd1), .wdata(ram_rdata),
        .wfull(resp_full),
        .rclk(clk_a), .rrst_n(rst_a_n), .rd_en(resp_pop), .rdata(resp_rdata),
        .rempty(resp_empty));

    slow_t s_q, s_d;

    always_comb begin
        resp_pop   = !resp_empty;
        s_d          = s_q;
        s_d.s1_valid = resp_pop;
        s_d.s1_data  = resp_pop ? resp_rdata : s_q.s1_data;
        s_d.a_valid  = s_q.s1_valid;
        s_d.a_rdata  = s_q.s1_valid ? s_q.s1_data : s_q.a_rdata;
    end

    always_ff @(posedge clk_a or negedge rst_a_n) begin
        if (!rst_a_n) s_q <= '0;
        else          s_q <= s_d;
    end

    assign a_valid = s_q.a_valid;
    assign a_rdata = s_q.a_rdata;

    // R3: no sampled read means b_rdata holds two edges later
    assert_b_hold_R3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !(b_ce && b_rd) |=> ##1 $stable(b_rdata));
endmodule

// File: tb/sim_dcram_emu.sv
`timescale 1ns/100ps
module sim_dcram_emu;
    localparam int DW = 16;
    localparam int AW = 6;

    logic clk_a = 0, clk_b = 0;
    logic rst_a_n = 0, rst_b_n = 0;
    logic a_ce = 0, a_wr = 0, a_rd = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic a_ready, a_valid;
    logic [DW-1:0] a_rdata, b_rdata;
    logic b_ce = 0, b_wr = 0, b_rd = 0;

    real half_a = 17.5;
    int  checks = 0, errors = 0;
    int  cyc_a = 0;
    bit  tight = 0, done = 0, b_busy = 0;
    int  hold_bad = 0;
    logic [DW-1:0] last_ard = '0;
    logic [DW-1:0] ref_m [64];
    logic [DW-1:0] exp_q [256];
    int  exp_iss [256];
    int  qh = 0, qt = 0;

    dcram_emu #(.DW(DW), .AW(AW)) u0 (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .a_ce(a_ce), .a_wr(a_wr), .a_rd(a_rd),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_ready(a_ready), .a_rdata(a_rdata),
        .a_valid(a_valid), .clk_b(clk_b), .rst_b_n(rst_b_n), .b_ce(b_ce),
        .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata));

    always #2.5 clk_b = ~clk_b;           // 200 MHz
    initial begin #1; forever #(half_a) clk_a = ~clk_a; end
    always @(posedge clk_a) cyc_a <= cyc_a + 1;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // port A response monitor
    always @(negedge clk_a) begin
        if (rst_a_n) begin
            if (a_valid) begin
                if (qh == qt) chk(0, "R6 unexpected a_valid", {16'h0, a_rdata}, 0);
                else begin
                    int lat;
                    lat = cyc_a - exp_iss[qh % 256];
                    chk(a_rdata == exp_q[qh % 256], "R6 port A read data", {16'h0, a_rdata}, {16'h0, exp_q[qh % 256]});
                    chk(lat >= 5, "R7 port A minimum latency", lat, 5);
                    if (tight) chk(lat <= 7, "R7 port A maximum latency", lat, 7);
                    qh++;
                end
            end else if (a_rdata !== last_ard) hold_bad++;
        end
        last_ard = a_rdata;
    end

    task automatic a_cmd(input logic ce, input logic wr, input logic rd, input logic [AW-1:0] ad,
                         input logic [DW-1:0] dt, output bit acc);
        @(negedge clk_a);
        a_ce = ce; a_wr = wr; a_rd = rd; a_addr = ad; a_wdata = dt;
        acc = ce && (wr || rd) && a_ready;
        if (acc) begin
            if (rd) begin
                exp_q[qt % 256] = ref_m[ad];
                exp_iss[qt % 256] = cyc_a + 1;
                qt++;
            end
            if (wr) ref_m[ad] = dt;
        end
    endtask

    task automatic a_idle();
        @(negedge clk_a);
        a_ce = 0; a_wr = 0; a_rd = 0;
    endtask

    task automatic b_drive(input logic ce, input logic wr, input logic rd, input logic [AW-1:0] ad,
                           input logic [DW-1:0] dt);
        @(negedge clk_b);
        b_ce = ce; b_wr = wr; b_rd = rd; b_addr = ad; b_wdata = dt;
        if (ce && wr) ref_m[ad] = dt;
    endtask

    task automatic b_idle();
        @(negedge clk_b);
        b_ce = 0; b_wr = 0; b_rd = 0;
    endtask

    task automatic drain();
        repeat (30) @(negedge clk_a);
        chk(qh == qt, "R6 all port A reads returned", qh, qt);
    endtask

    task automatic do_reset(input real half);
        rst_a_n = 0; rst_b_n = 0;
        a_ce = 0; a_wr = 0; a_rd = 0; b_ce = 0; b_wr = 0; b_rd = 0;
        half_a = half;
        repeat (4) @(posedge clk_a);
        @(negedge clk_a);
        rst_a_n = 1; rst_b_n = 1;
        repeat (2) @(negedge clk_a);
    endtask

    // port B traffic on the low half, idle every other cycle (R9)
    task automatic b_stream(input int n);
        logic [DW-1:0] pend = '0;
        logic [AW-1:0] ad = '0;
        bit have = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk_b);
            if (k % 4 == 0 && have) begin
                chk(b_rdata == pend, "R9 port B latency under port A load", {16'h0, b_rdata}, {16'h0, pend});
                have = 0;
            end
            case (k % 4)
                0: begin
                    ad = 6'((k / 4) % 32);
                    pend = 16'hC000 ^ 16'(k);
                    b_ce = 1; b_wr = 1; b_rd = 0; b_addr = ad; b_wdata = pend;
                    ref_m[ad] = pend;
                end
                2: begin
                    b_ce = 1; b_wr = 0; b_rd = 1; b_addr = ad;
                    have = 1;
                end
                default: begin b_ce = 0; b_wr = 0; b_rd = 0; end
            endcase
        end
        b_idle();
    endtask

    typedef struct packed {
        logic ce; logic wr; logic rd;
        logic [AW-1:0] ad; logic [DW-1:0] dt;
        logic ck; logic [DW-1:0] ex;
    } bvec_t;

    localparam int NB = 12;
    localparam bvec_t BTAB [NB] = '{
        '{1'b1, 1'b1, 1'b0, 6'd3, 16'h1111, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 1'b0, 6'd5, 16'h2222, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 1'b1, 6'd3, 16'h0000, 1'b1, 16'h1111},  // R1
        '{1'b1, 1'b0, 1'b1, 6'd5, 16'h0000, 1'b1, 16'h2222},  // R1
        '{1'b0, 1'b1, 1'b0, 6'd5, 16'h4444, 1'b1, 16'h2222},  // R2 ce low, R3 hold
        '{1'b1, 1'b0, 1'b1, 6'd5, 16'h0000, 1'b1, 16'h2222},  // R2 write ignored
        '{1'b1, 1'b1, 1'b1, 6'd3, 16'h3333, 1'b1, 16'h1111},  // R1 read-first
        '{1'b1, 1'b0, 1'b1, 6'd3, 16'h0000, 1'b1, 16'h3333},  // R2
        '{1'b1, 1'b1, 1'b0, 6'd7, 16'h5555, 1'b1, 16'h3333},  // R3 hold on write
        '{1'b1, 1'b0, 1'b1, 6'd7, 16'h0000, 1'b1, 16'h5555},  // R1
        '{1'b0, 1'b0, 1'b1, 6'd3, 16'h0000, 1'b1, 16'h5555},  // R3 ce-low read
        '{1'b1, 1'b1, 1'b0, 6'd3, 16'h6666, 1'b1, 16'h5555}   // R3 hold on write
    };

    initial begin
        bit acc;
        int cnt;
        for (int i = 0; i < 64; i++) ref_m[i] = '0;

        // ---------------- ratio 7 ----------------
        do_reset(17.5);
        chk(a_ready == 1'b1, "R4 a_ready after reset", a_ready, 1);
        chk(a_valid == 1'b0, "R6 a_valid after reset", a_valid, 0);
        chk(a_rdata == '0, "R6 a_rdata after reset", a_rdata, 0);
        chk(b_rdata == '0, "R3 b_rdata after reset", b_rdata, 0);

        // port B vector table (R1 R2 R3)
        for (int i = 0; i < NB + 2; i++) begin
            @(negedge clk_b);
            if (i >= 2 && BTAB[i-2].ck)
                chk(b_rdata == BTAB[i-2].ex, $sformatf("R1 R2 R3 port B entry %0d", i - 2),
                    {16'h0, b_rdata}, {16'h0, BTAB[i-2].ex});
            if (i < NB) begin
                b_ce = BTAB[i].ce; b_wr = BTAB[i].wr; b_rd = BTAB[i].rd;
                b_addr = BTAB[i].ad; b_wdata = BTAB[i].dt;
                if (BTAB[i].ce && BTAB[i].wr) ref_m[BTAB[i].ad] = BTAB[i].dt;
            end else begin
                b_ce = 0; b_wr = 0; b_rd = 0;
            end
        end

        // R8: port B write seen by port A; R7 bound with port B idle
        tight = 1;
        b_drive(1, 1, 0, 6'd10, 16'hBEEF);
        b_idle();
        repeat (2) @(negedge clk_a);
        a_cmd(1, 0, 1, 6'd10, '0, acc);
        chk(acc, "R4 port A read accepted", acc, 1);
        a_idle();
        drain();

        // R8: port A write seen by port B
        a_cmd(1, 1, 0, 6'd40, 16'hA5A5, acc);
        a_cmd(1, 0, 1, 6'd40, '0, acc);
        a_cmd(1, 1, 1, 6'd40, 16'h1234, acc);     // R6 read-first, expects A5A5
        a_cmd(1, 1, 0, 6'd41, 16'h0041, acc);
        a_cmd(0, 1, 0, 6'd41, 16'hDEAD, acc);     // R4 a_ce low ignored
        a_cmd(1, 0, 1, 6'd41, '0, acc);
        a_idle();
        drain();
        b_drive(1, 0, 1, 6'd40, '0);
        b_idle();
        @(negedge clk_b);
        chk(b_rdata == 16'h1234, "R8 port A write read on port B", {16'h0, b_rdata}, 32'h1234);
        tight = 0;

        // concurrent traffic at ratio 7 then 10 (R9 R6 R7)
        for (int ph = 0; ph < 2; ph++) begin
            if (ph == 1) do_reset(25.0);
            fork
                begin
                    for (int i = 0; i < 40; i++) begin
                        if (i % 2 == 0) a_cmd(1, 1, 0, 6'(32 + (i % 16)), 16'h7000 + 16'(i + 100 * ph), acc);
                        else            a_cmd(1, 0, 1, 6'(32 + ((i - 1) % 16)), '0, acc);
                    end
                    a_idle();
                end
                b_stream(400);
            join
            drain();
        end

        // R5: full command FIFO with port B busy every cycle (ratio 10)
        b_busy = 1;
        fork
            begin
                repeat (3) @(negedge clk_a);
                cnt = 0;
                for (int i = 0; i < 80; i++) begin
                    a_cmd(1, 1, 0, 6'(32 + (i % 32)), 16'h8000 + 16'(i), acc);
                    if (!acc) break;
                    cnt++;
                end
                chk(cnt == 64, "R5 accepted commands before a_ready low", cnt, 64);
                a_idle();
                chk(a_ready == 1'b0, "R5 a_ready stays low while full", a_ready, 0);
                b_busy = 0;
            end
            begin
                while (b_busy) begin
                    @(negedge clk_b);
                    b_ce = 1; b_wr = 0; b_rd = 1; b_addr = '0;
                end
                b_idle();
            end
        join
        repeat (20) @(negedge clk_a);
        chk(a_ready == 1'b1, "R5 a_ready returns after drain", a_ready, 1);
        for (int j = 0; j < 32; j++) a_cmd(1, 0, 1, 6'(32 + j), '0, acc);
        a_idle();
        drain();
        chk(ref_m[32] == 16'h8020, "R5 dropped write not modelled", {16'h0, ref_m[32]}, 32'h8020);
        chk(hold_bad == 0, "R6 a_rdata held while a_valid low", hold_bad, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule